// File: doc/BRIEF.md
# Receive Frame Forwarding Gate

This block sits between the receive side of an Ethernet MAC and the receive FIFO and DMA request logic. It takes a byte stream that carries start and end markers. For each frame it decides whether the frame is kept in the FIFO or dropped. For a kept frame it also decides on which byte the DMA is told to start moving it. A dropped frame is removed by setting the FIFO write pointer back to the address where that frame began. The last byte of a kept frame is written with an end flag and a three-bit status word, so the consumer can find where each frame ends.

The address-filter verdict arrives as a one-cycle strobe at any beat of the frame. Four configuration inputs steer the decisions:

- a pass-everything switch;
- a store-and-forward switch;
- a 2-bit threshold selector;
- a switch that keeps short frames instead of flushing them.

The control is a three-state machine:

- `S_IDLE` waits for a start beat. On the start beat it goes to `S_COLLECT`. It goes to `S_DISCARD` if that beat is dropped and is not also the end beat. It stays in `S_IDLE` for a one-beat frame.
- `S_COLLECT` writes bytes. On an end beat it returns to `S_IDLE`. It moves to `S_DISCARD` when a non-end beat is dropped.
- `S_DISCARD` swallows bytes and returns to `S_IDLE` on an end beat.

Top module: `rx_fwd_gate`

## Requirements
- R1: After reset, `fifo_wr_en`, `fifo_wr_last`, `fifo_drop` and `dma_start` are 0, and `fifo_wr_ptr` is 0.
- R2: When the filter strobe reports a mismatch and `cfg_rx_all` is 0, the frame is dropped on that beat. The beat is not written, and no later byte of the frame is written.
- R3: With `cfg_rx_all` set, no frame is dropped for its filter result. Status bit 2 is 1 when the frame had no filter match (mismatch, or no verdict).
- R4: With `cfg_store_fwd` at 0, the forward point is max(64, (`cfg_thr`+1)*32) bytes. `dma_start` pulses one cycle after the first beat on which all of these hold:
  - the byte count has reached the forward point;
  - the frame is passed (`cfg_rx_all` set, or a match reported at or before that beat).
  It also pulses one cycle after the end beat of a passed frame that has 64 to forward-point-minus-1 bytes.
- R5: With `cfg_store_fwd` at 1, `dma_start` pulses only in the same cycle as the written last byte of a passed frame of at least 64 bytes.
- R6: A frame ending with fewer than 64 bytes never raises `dma_start`. With `cfg_no_flush` at 0 it is dropped. With `cfg_no_flush` at 1 it stays in the FIFO, with status bit 0 set.
- R7: `dma_start` pulses at most once per frame, never in the same cycle as `fifo_drop`, and never before byte 64.
- R8: Each kept byte appears on `fifo_wr_data` one cycle after its beat, with `fifo_wr_en` high. Addresses run consecutively. The last byte carries `fifo_wr_last` and a status word: bit 0 short, bit 1 `in_abort` seen on the end beat, bit 2 no filter match.
- R9: A drop raises `fifo_drop` one cycle after the deciding beat. `fifo_wr_ptr` then equals the address at which the frame began.
- R10: Beats without a start marker while in `S_IDLE` are ignored. A frame whose end beat arrives with no filter verdict, and with `cfg_rx_all` at 0, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat present |
| in_data | input | DW | Received byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_abort | input | 1 | Collision or early termination, valid with `in_eof` |
| filt_valid | input | 1 | Address-filter verdict strobe |
| filt_pass | input | 1 | Verdict: 1 match, 0 mismatch |
| cfg_rx_all | input | 1 | Pass every frame regardless of filter |
| cfg_store_fwd | input | 1 | Forward only after the whole frame is in the FIFO |
| cfg_thr | input | 2 | Threshold select: 32/64/96/128 bytes |
| cfg_no_flush | input | 1 | Keep short frames |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_addr | output | AW | Write address |
| fifo_wr_data | output | DW | Write data |
| fifo_wr_last | output | 1 | Word is last of its frame |
| fifo_wr_stat | output | 3 | Frame status with last word |
| fifo_wr_ptr | output | AW | Next free FIFO address |
| fifo_drop | output | 1 | Frame dropped, pointer rewound |
| dma_start | output | 1 | DMA may start moving the frame |

## Verification
Every output is registered once, so each result belongs to the beat presented one clock earlier. That covers:

- the write strobe, address, data, last flag and status;
- the drop pulse and the rewound pointer;
- the start pulse.

The bench drives each beat on a falling edge and compares all outputs at the next falling edge against values computed for that beat. A mismatch is therefore tied to a single beat. The sweep covers both forwarding modes, all four threshold codes, both override switches, frame lengths on each side of 64 and of the forward points, and filter verdicts that arrive early, late, negative or never.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_DISCARD = 2'd2
    } rxg_state_e;

    typedef struct packed {
        logic bypass;
        logic abort;
        logic runt;
    } rxg_stat_t;

    function automatic int unsigned fwd_point(input logic [1:0] sel,
                                              input int unsigned step,
                                              input int unsigned floor_b);
        int unsigned raw;
        raw = (int'(sel) + 1) * step;
        return (raw < floor_b) ? floor_b : raw;
    endfunction
endpackage

// File: rtl/rxg_len_ctr.sv
module rxg_len_ctr #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          first,
    output logic [CW-1:0] cnt_nxt,
    output logic [CW-1:0] cnt_q
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_base;

    always_comb begin
        cnt_base = first ? '0 : cnt_q;
        cnt_nxt  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (beat)
            cnt_q <= cnt_nxt;
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !first && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rxg_start_dec.sv
module rxg_start_dec #(
    parameter int CW       = 14,
    parameter int THR_STEP = 32,
    parameter int RUNT_MIN = 64
) (
    input  logic          en,
    input  logic          cfg_store_fwd,
    input  logic [1:0]    cfg_thr,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          last,
    input  logic          ok,
    input  logic          started,
    input  logic          drop,
    output logic          start
);
    import rxg_pkg::*;

    logic [CW-1:0] fwd_at;
    logic          long_enough;
    logic          reached;

    always_comb begin
        fwd_at      = CW'(fwd_point(cfg_thr, THR_STEP, RUNT_MIN));
        long_enough = (cnt_nxt >= CW'(RUNT_MIN));
        reached     = cfg_store_fwd ? (last && long_enough)
                                    : ((cnt_nxt >= fwd_at) || (last && long_enough));
        start       = en && !started && !drop && ok && reached;
    end

    // R7
    always_comb begin
        if (start) runt_never_started_chk: assert (cnt_nxt >= CW'(RUNT_MIN));
    end
endmodule

// File: rtl/rxg_wr_stage.sv
module rxg_wr_stage #(
    parameter int DW = 8,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first_beat,
    input  logic          wr,
    input  logic          drop,
    input  logic          last,
    input  logic [2:0]    stat,
    input  logic [DW-1:0] data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_last,
    output logic [2:0]    wr_stat,
    output logic          drop_q,
    output logic [AW-1:0] ptr_q
);
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            base_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_last <= 1'b0;
            wr_stat <= '0;
            drop_q  <= 1'b0;
        end else begin
            wr_en   <= wr;
            wr_last <= wr && last;
            drop_q  <= drop;
            if (first_beat)
                base_q <= ptr_q;
            if (wr) begin
                wr_addr <= ptr_q;
                wr_data <= data;
                wr_stat <= last ? stat : 3'b000;
                ptr_q   <= ptr_q + 1'b1;
            end else if (drop) begin
                ptr_q <= first_beat ? ptr_q : base_q;
            end
        end
    end

    // R9
    rewind_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> (ptr_q == base_q));
    // R8
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr_q == wr_addr + 1'b1));
endmodule

// File: rtl/rx_fwd_gate.sv
module rx_fwd_gate #(
    parameter int DW       = 8,
    parameter int AW       = 12,
    parameter int CW       = 14,
    parameter int THR_STEP = 32,
    parameter int RUNT_MIN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_abort,
    input  logic          filt_valid,
    input  logic          filt_pass,
    input  logic          cfg_rx_all,
    input  logic          cfg_store_fwd,
    input  logic [1:0]    cfg_thr,
    input  logic          cfg_no_flush,
    output logic          fifo_wr_en,
    output logic [AW-1:0] fifo_wr_addr,
    output logic [DW-1:0] fifo_wr_data,
    output logic          fifo_wr_last,
    output logic [2:0]    fifo_wr_stat,
    output logic [AW-1:0] fifo_wr_ptr,
    output logic          fifo_drop,
    output logic          dma_start
);
    import rxg_pkg::*;

    rxg_state_e    st_q, st_d;
    logic          known_q, praw_q, started_q;
    logic          first, in_frame, known_c, praw_c, started_c;
    logic          ok_c, rej_c, runt_c, drop_c, wr_c, start_c;
    rxg_stat_t     stat_c;
    logic [CW-1:0] cnt_nxt, cnt_q;

    always_comb begin
        first     = (st_q == S_IDLE);
        in_frame  = in_valid && ((first && in_sof) || (st_q == S_COLLECT));
        known_c   = (!first && known_q) || filt_valid;
        praw_c    = filt_valid ? filt_pass : (!first && praw_q);
        started_c = !first && started_q;
        ok_c      = cfg_rx_all || (known_c && praw_c);
        rej_c     = !cfg_rx_all && ((known_c && !praw_c) || (in_eof && !known_c));
        runt_c    = in_eof && (cnt_nxt < CW'(RUNT_MIN));
        drop_c    = in_frame && (rej_c || (runt_c && !cfg_no_flush));
        wr_c      = in_frame && !drop_c;
        stat_c    = '{bypass: !(known_c && praw_c), abort: in_abort, runt: runt_c};
        st_d      = st_q;
        unique case (st_q)
            S_IDLE, S_COLLECT:
                if (in_frame)
                    st_d = in_eof ? S_IDLE : (drop_c ? S_DISCARD : S_COLLECT);
            S_DISCARD:
                if (in_valid && in_eof) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            known_q   <= 1'b0;
            praw_q    <= 1'b0;
            started_q <= 1'b0;
            dma_start <= 1'b0;
        end else begin
            dma_start <= start_c;
            if (in_frame) begin
                known_q   <= known_c;
                praw_q    <= praw_c;
                started_q <= started_c || start_c;
            end
        end
    end

    rxg_len_ctr #(.CW(CW)) u_len (
        .clk(clk), .rst_n(rst_n), .beat(in_frame), .first(first),
        .cnt_nxt(cnt_nxt), .cnt_q(cnt_q)
    );

    rxg_start_dec #(.CW(CW), .THR_STEP(THR_STEP), .RUNT_MIN(RUNT_MIN)) u_start (
        .en(in_frame), .cfg_store_fwd(cfg_store_fwd), .cfg_thr(cfg_thr),
        .cnt_nxt(cnt_nxt), .last(in_eof), .ok(ok_c), .started(started_c),
        .drop(drop_c), .start(start_c)
    );

    rxg_wr_stage #(.DW(DW), .AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .first_beat(in_frame && first),
        .wr(wr_c), .drop(drop_c), .last(in_eof), .stat(stat_c), .data(in_data),
        .wr_en(fifo_wr_en), .wr_addr(fifo_wr_addr), .wr_data(fifo_wr_data),
        .wr_last(fifo_wr_last), .wr_stat(fifo_wr_stat), .drop_q(fifo_drop),
        .ptr_q(fifo_wr_ptr)
    );

    // R7
    no_start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && fifo_drop));
    // R2
    no_wr_in_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DISCARD) |-> !fifo_wr_en);
    // R5
    saf_start_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start && cfg_store_fwd) |-> fifo_wr_last);
endmodule

// File: tb/tb_rx_fwd_gate.sv
module tb_rx_fwd_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
    logic [7:0]  in_data = '0;
    logic        filt_valid = 1'b0, filt_pass = 1'b0;
    logic        cfg_rx_all = 1'b0, cfg_store_fwd = 1'b0, cfg_no_flush = 1'b0;
    logic [1:0]  cfg_thr = '0;
    logic        fifo_wr_en, fifo_wr_last, fifo_drop, dma_start;
    logic [11:0] fifo_wr_addr, fifo_wr_ptr;
    logic [7:0]  fifo_wr_data;
    logic [2:0]  fifo_wr_stat;

    int unsigned n_tests = 0, n_fail = 0, cycles = 0;
    logic [11:0] m_ptr = '0;
    int          frame_no = 0;

    always #4 clk = ~clk;

    rx_fwd_gate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
        .filt_valid(filt_valid), .filt_pass(filt_pass), .cfg_rx_all(cfg_rx_all),
        .cfg_store_fwd(cfg_store_fwd), .cfg_thr(cfg_thr), .cfg_no_flush(cfg_no_flush),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_addr(fifo_wr_addr), .fifo_wr_data(fifo_wr_data),
        .fifo_wr_last(fifo_wr_last), .fifo_wr_stat(fifo_wr_stat), .fifo_wr_ptr(fifo_wr_ptr),
        .fifo_drop(fifo_drop), .dma_start(dma_start)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s frame %0d: got %0d expected %0d", tag, frame_no, got, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 190000", cycles);
            summary();
        end
    end

    task automatic run_frame(input bit saf, input logic [1:0] thr, input bit ra, input bit nf,
                             input int len, input int fpos, input bit fpass, input bit ab);
        bit known = 0, praw = 0, disc = 0, started = 0;
        int starts = 0;
        int fwd;
        logic [11:0] base = m_ptr;
        fwd = (int'(thr) + 1) * 32;
        if (fwd < 64) fwd = 64;
        cfg_store_fwd = saf; cfg_thr = thr; cfg_rx_all = ra; cfg_no_flush = nf;
        @(negedge clk);
        @(negedge clk);
        for (int k = 1; k <= len; k++) begin
            bit last, ok, rej, runt, e_dr, e_wr, e_st;
            logic [11:0] addr;
            logic [7:0]  dat;
            last = (k == len);
            dat  = 8'((k + frame_no) & 255);
            in_valid = 1'b1; in_sof = (k == 1); in_eof = last; in_data = dat;
            filt_valid = (k == fpos); filt_pass = fpass; in_abort = ab && last;
            if (k == fpos) begin known = 1; praw = fpass; end
            ok   = ra || (known && praw);
            rej  = !ra && ((known && !praw) || (last && !known));
            runt = last && (k < 64);
            e_dr = !disc && (rej || (runt && !nf));
            e_wr = !disc && !e_dr;
            e_st = e_wr && !started && ok &&
                   (saf ? (last && k >= 64) : (k >= fwd || (last && k >= 64)));
            addr = m_ptr;
            if (e_dr) m_ptr = base;
            else if (e_wr) m_ptr = m_ptr + 1'b1;
            @(negedge clk);
            chk(dma_start == e_st, saf ? "R5" : "R4", dma_start, e_st);
            chk(fifo_wr_en == e_wr, "R8", fifo_wr_en, e_wr);
            chk(fifo_drop == e_dr, "R9", fifo_drop, e_dr);
            chk(fifo_wr_ptr == m_ptr, "R9", fifo_wr_ptr, m_ptr);
            if (e_wr) begin
                chk(fifo_wr_addr == addr && fifo_wr_data == dat, "R8",
                    {fifo_wr_addr, fifo_wr_data}, {addr, dat});
                chk(fifo_wr_last == last, "R8", fifo_wr_last, last);
                if (last)
                    chk(fifo_wr_stat == {!(known && praw), ab, runt}, "R8",
                        fifo_wr_stat, {!(known && praw), ab, runt});
            end
            if (dma_start) starts++;
            if (e_st) started = 1;
            if (e_dr && !last) disc = 1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; filt_valid = 1'b0; in_abort = 1'b0;
        // R7: a single start per frame
        chk(starts <= 1, "R7", starts, 1);
        // R6: short frame removed when flushing
        if (len < 64 && !nf) chk(m_ptr == base, "R6", m_ptr, base);
        // R3: pass-everything keeps the whole frame
        if (ra && (len >= 64 || nf)) chk(m_ptr == base + 12'(len), "R3", m_ptr, base + 12'(len));
        // R2: mismatch with no override leaves nothing
        if (!ra && fpos > 0 && fpos <= len && !fpass) chk(m_ptr == base, "R2", m_ptr, base);
        // R10: no verdict by the end beat drops the frame
        if (!ra && (fpos == 0 || fpos > len)) chk(m_ptr == base, "R10", m_ptr, base);
        frame_no++;
        @(negedge clk);
    endtask

    initial begin
        int lens[8]  = '{1, 40, 63, 64, 65, 100, 128, 130};
        int fposv[5] = '{1, 10, 10, 100, 0};
        bit fpv[5]   = '{1, 1, 0, 1, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({fifo_wr_en, fifo_wr_last, fifo_drop, dma_start} == 4'b0, "R1",
            {fifo_wr_en, fifo_wr_last, fifo_drop, dma_start}, 0);
        chk(fifo_wr_ptr == 12'd0, "R1", fifo_wr_ptr, 0);
        // R10: stray beats without a start marker
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'(i); in_eof = (i == 2);
            @(negedge clk);
            chk(!fifo_wr_en && !dma_start && fifo_wr_ptr == 12'd0, "R10",
                {fifo_wr_en, dma_start}, 0);
        end
        in_valid = 1'b0; in_eof = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 4; t++)
                for (int r = 0; r < 2; r++)
                    for (int n = 0; n < 2; n++)
                        for (int l = 0; l < 8; l++)
                            for (int f = 0; f < 5; f++)
                                run_frame(s[0], 2'(t), r[0], n[0], lens[l],
                                          fposv[f], fpv[f], l[0]);
        summary();
    end
endmodule